// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block carries out single-byte DMA transfers for a controller with four channels. Each channel stores a mode, a base address and a base count, plus a working address and a working count. Software-side logic loads these through a configuration port. A step strobe names one channel. If that channel is unmasked and the sequencer is idle, the sequencer runs two phases. In the first phase it reads one byte into a temporary register. In the second phase it writes that byte out. It then moves the channel's working address by one and decrements its count.

A transfer that takes the count past zero is a terminal count. The channel's status bit goes high. The channel then either reloads from its base values or masks itself. A per-channel flag shows when the last step carried the address across a 256-byte page. The upper address byte needs re-driving at that point.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset every mask bit is 1, every status bit and page flag is 0, busy is 0, no strobe is active and the temporary byte (`wr_data`) is 0.
- R2: A configuration write, taken only while idle, does the following for the addressed channel. It loads the mode, the base and working address, and the base and working count. It clears that channel's mask bit, status bit and page flag. Mode bits [1:0] select the transfer type: 00 verify, 01 write (I/O to memory), 10 read (memory to I/O), 11 illegal. Bit 2 set means the address decrements. Bit 3 set enables auto-reload.
- R3: A step is accepted only when the sequencer is idle and the named channel is unmasked. An accepted step holds `busy` for exactly two cycles, a read phase and then a write phase. A step on a masked channel, or one raised while busy, has no effect.
- R4: A write-type transfer pulses `io_rd` in the read phase and captures `io_rdata`. It then pulses `mem_wr` in the write phase with the captured byte on `wr_data`. `bus_addr` holds the channel's working address in both phases.
- R5: A read-type transfer pulses `mem_rd` at the working address in the read phase and captures `mem_rdata`. It then pulses `io_wr` with that byte in the write phase.
- R6: A verify-type transfer raises no strobe and leaves the temporary byte unchanged. It still advances the address and the count.
- R7: An illegal-type transfer raises no strobe. It leaves the address, count, page flag, status and mask of the channel unchanged.
- R8: After a non-illegal transfer the working address is one lower when mode bit 2 is set, and one higher when it is clear. The address wraps modulo 2^16.
- R9: A non-illegal transfer sets the page flag when the new low address byte is 0xFF on a decrement, or 0x00 on an increment. Otherwise the transfer clears the flag.
- R10: A non-illegal transfer decrements the 16-bit count. When the new count is 0xFFFF, status bit n goes high for channel n. It stays high until that channel is configured again.
- R11: At terminal count with auto-reload set, the address and count reload from the base values, the page flag goes high, and the mask bit stays clear.
- R12: At terminal count without auto-reload, the channel's mask bit goes high. The address keeps its stepped value and the count reads 0xFFFF.
- R13: At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel to configure |
| cfg_mode | input | 4 | Mode: type [1:0], decrement [2], auto-reload [3] |
| cfg_addr | input | 16 | Base and starting address |
| cfg_cnt | input | 16 | Base and starting count |
| step | input | 1 | Request one transfer |
| svc_chan | input | 2 | Channel to serve |
| mem_rdata | input | 8 | Byte returned by memory |
| io_rdata | input | 8 | Byte returned by the I/O device |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| act_chan | output | 2 | Channel of the transfer in progress |
| bus_addr | output | 16 | Transfer address while busy, 0 when idle |
| wr_data | output | 8 | Temporary byte register |
| busy | output | 1 | Transfer in progress |
| peek_chan | input | 2 | Channel shown on the peek outputs |
| peek_addr | output | 16 | Working address of the peeked channel |
| peek_cnt | output | 16 | Working count of the peeked channel |
| tc_status | output | 4 | Terminal-count status, bit n for channel n |
| mask | output | 4 | Mask bits, bit n for channel n |
| hi_chg | output | 4 | Page-crossing flags, bit n for channel n |

## Verification
The assertions check on every cycle the properties that hold whatever was programmed. These are: at most one strobe at a time, a read strobe always followed by the matching write strobe, the written byte equal to the one captured, the two-cycle busy span, a masked step never starting a transfer, and status and mask bits never clearing without a configuration write. The arithmetic can only be shown by the bench's scenarios, which compare the peeked values against an independent model. That covers the address direction and wrap, page-crossing detection, the count wrap at zero, the choice between reload and masking, and the untouched state after illegal or ignored steps.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    XF_VERIFY  = 2'b00,
    XF_WRITE   = 2'b01,
    XF_READ    = 2'b10,
    XF_ILLEGAL = 2'b11
  } xfer_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_READ  = 2'b01,
    PH_WRITE = 2'b10
  } phase_e;

  localparam int MODE_W        = 4;
  localparam int MODE_DEC_BIT  = 2;
  localparam int MODE_AUTO_BIT = 3;

  function automatic xfer_e mode_xfer(input logic [MODE_W-1:0] m);
    return xfer_e'(m[1:0]);
  endfunction

  function automatic logic mode_dec(input logic [MODE_W-1:0] m);
    return m[MODE_DEC_BIT];
  endfunction

  function automatic logic mode_auto(input logic [MODE_W-1:0] m);
    return m[MODE_AUTO_BIT];
  endfunction

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [CHW-1:0] svc_chan,
  input  logic [NCH-1:0] mask,
  output logic           ph_rd,
  output logic           ph_wr,
  output logic           busy,
  output logic           start_ev,
  output logic [CHW-1:0] act_chan
);

  phase_e         ph_q, ph_d;
  logic [CHW-1:0] chan_q;

  // A step starts a transfer only from idle and only for an unmasked channel.
  assign start_ev = (ph_q == PH_IDLE) && step && !mask[svc_chan];

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (start_ev) ph_d = PH_READ;
      PH_READ:  ph_d = PH_WRITE;
      PH_WRITE: ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      chan_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (start_ev) chan_q <= svc_chan;
    end
  end

  assign ph_rd    = (ph_q == PH_READ);
  assign ph_wr    = (ph_q == PH_WRITE);
  assign busy     = ph_rd || ph_wr;
  assign act_chan = chan_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int PGB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_go,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic              adv,
  output xfer_e             xf_o,
  output logic [AW-1:0]     addr_o,
  output logic [CW-1:0]     cnt_o,
  output logic              mask_o,
  output logic              tc_o,
  output logic              hflag_o,
  output logic              tc_ev_o
);

  logic [MODE_W-1:0] mode_q;
  logic [AW-1:0]     base_a, cur_a, a_next;
  logic [CW-1:0]     base_c, cur_c, c_next;
  logic              mask_q, tc_q, hf_q;
  logic              dec, autold, wrap;

  // Address moves by one in the direction the mode selects, wrapping freely.
  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a, input logic down);
    return down ? (a - 1'b1) : (a + 1'b1);
  endfunction

  // The page flag marks an address that has just left its 2^PGB block.
  function automatic logic page_cross(input logic [AW-1:0] a_new, input logic down);
    return down ? (a_new[PGB-1:0] == {PGB{1'b1}}) : (a_new[PGB-1:0] == {PGB{1'b0}});
  endfunction

  // Terminal count: the count has rolled under zero.
  function automatic logic cnt_rolled(input logic [CW-1:0] c_new);
    return c_new == {CW{1'b1}};
  endfunction

  assign dec     = mode_dec(mode_q);
  assign autold  = mode_auto(mode_q);
  assign a_next  = addr_step(cur_a, dec);
  assign c_next  = cur_c - 1'b1;
  assign wrap    = cnt_rolled(c_next);
  assign tc_ev_o = adv && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      base_a <= '0;
      base_c <= '0;
      cur_a  <= '0;
      cur_c  <= '0;
      mask_q <= 1'b1;
      tc_q   <= 1'b0;
      hf_q   <= 1'b0;
    end else if (cfg_go) begin
      mode_q <= cfg_mode;
      base_a <= cfg_addr;
      cur_a  <= cfg_addr;
      base_c <= cfg_cnt;
      cur_c  <= cfg_cnt;
      mask_q <= 1'b0;
      tc_q   <= 1'b0;
      hf_q   <= 1'b0;
    end else if (adv) begin
      if (wrap) tc_q <= 1'b1;
      if (wrap && autold) begin
        cur_a <= base_a;
        cur_c <= base_c;
        hf_q  <= 1'b1;
      end else begin
        cur_a <= a_next;
        cur_c <= c_next;
        hf_q  <= page_cross(a_next, dec);
        if (wrap) mask_q <= 1'b1;
      end
    end
  end

  assign xf_o    = mode_xfer(mode_q);
  assign addr_o  = cur_a;
  assign cnt_o   = cur_c;
  assign mask_o  = mask_q;
  assign tc_o    = tc_q;
  assign hflag_o = hf_q;

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 8,
  parameter int PGB = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_chan,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic              step,
  input  logic [CHW-1:0]    svc_chan,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [DW-1:0]     io_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic [CHW-1:0]    act_chan,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     wr_data,
  output logic              busy,
  input  logic [CHW-1:0]    peek_chan,
  output logic [AW-1:0]     peek_addr,
  output logic [CW-1:0]     peek_cnt,
  output logic [NCH-1:0]    tc_status,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    hi_chg
);

  logic          ph_rd, ph_wr, start_ev;
  logic          cfg_go;
  logic          adv_ev;
  logic          tc_ev;
  xfer_e         xf_act;
  logic [DW-1:0] temp_q;

  xfer_e         ch_xf   [NCH];
  logic [AW-1:0] ch_addr [NCH];
  logic [CW-1:0] ch_cnt  [NCH];
  logic [NCH-1:0] ch_tcev;

  dma_seq_ctrl #(.NCH(NCH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .svc_chan (svc_chan),
    .mask     (mask),
    .ph_rd    (ph_rd),
    .ph_wr    (ph_wr),
    .busy     (busy),
    .start_ev (start_ev),
    .act_chan (act_chan)
  );

  // Configuration is refused while a transfer is in flight.
  assign cfg_go = cfg_we && !busy;
  assign xf_act = ch_xf[act_chan];
  // A channel advances at the end of the write phase unless its type is illegal.
  assign adv_ev = ph_wr && (xf_act != XF_ILLEGAL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_cfg, sel_adv;
    assign sel_cfg = cfg_go && (cfg_chan == CHW'(i));
    assign sel_adv = adv_ev && (act_chan == CHW'(i));

    dma_chan_regs #(.AW(AW), .CW(CW), .PGB(PGB)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_go   (sel_cfg),
      .cfg_mode (cfg_mode),
      .cfg_addr (cfg_addr),
      .cfg_cnt  (cfg_cnt),
      .adv      (sel_adv),
      .xf_o     (ch_xf[i]),
      .addr_o   (ch_addr[i]),
      .cnt_o    (ch_cnt[i]),
      .mask_o   (mask[i]),
      .tc_o     (tc_status[i]),
      .hflag_o  (hi_chg[i]),
      .tc_ev_o  (ch_tcev[i])
    );
  end

  assign tc_ev = |ch_tcev;

  // Strobe decode: the type picks which side is read and which is written.
  assign mem_rd = ph_rd && (xf_act == XF_READ);
  assign io_rd  = ph_rd && (xf_act == XF_WRITE);
  assign mem_wr = ph_wr && (xf_act == XF_WRITE);
  assign io_wr  = ph_wr && (xf_act == XF_READ);

  assign bus_addr = busy ? ch_addr[act_chan] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
    end else if (io_rd) begin
      temp_q <= io_rdata;
    end else if (mem_rd) begin
      temp_q <= mem_rdata;
    end
  end

  assign wr_data   = temp_q;
  assign peek_addr = ch_addr[peek_chan];
  assign peek_cnt  = ch_cnt[peek_chan];

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           step,
  input logic [CHW-1:0] svc_chan,
  input logic [DW-1:0]  mem_rdata,
  input logic [DW-1:0]  io_rdata,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic [CHW-1:0] act_chan,
  input logic [DW-1:0]  wr_data,
  input logic           busy,
  input logic [NCH-1:0] tc_status,
  input logic [NCH-1:0] mask,
  input logic           cfg_go,
  input logic           tc_ev
);

  p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

  p_io_then_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> mem_wr);

  p_mem_then_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> io_wr);

  p_mem_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> (wr_data == $past(io_rdata)));

  p_io_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (wr_data == $past(mem_rdata)));

  p_busy_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (busy ##1 !busy));

  p_masked_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && step && mask[svc_chan]) |=> !busy);

  p_tc_sets_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tc_ev |=> tc_status[$past(act_chan)]);

  p_sticky_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_go |=> (((tc_status & $past(tc_status)) == $past(tc_status)) &&
                 ((mask & $past(mask)) == $past(mask))));

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (step),
  .svc_chan  (svc_chan),
  .mem_rdata (mem_rdata),
  .io_rdata  (io_rdata),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .act_chan  (act_chan),
  .wr_data   (wr_data),
  .busy      (busy),
  .tc_status (tc_status),
  .mask      (mask),
  .cfg_go    (cfg_go),
  .tc_ev     (tc_ev)
);

// File: tb/dma_xfer_seq_tb.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_chan;
  logic [3:0]  cfg_mode;
  logic [15:0] cfg_addr, cfg_cnt;
  logic        step;
  logic [1:0]  svc_chan, peek_chan, act_chan;
  logic [7:0]  mem_rdata, io_rdata, wr_data;
  logic        mem_rd, mem_wr, io_rd, io_wr, busy;
  logic [15:0] bus_addr, peek_addr, peek_cnt;
  logic [3:0]  tc_status, mask, hi_chg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model of the four channels
  logic [3:0]  m_mode [4];
  logic [15:0] m_addr [4], m_cnt [4], m_ba [4], m_bc [4];
  logic [3:0]  m_mask, m_tc, m_hf;
  logic [7:0]  m_temp;

  always #2.5 clk = ~clk;

  dma_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_mode(cfg_mode), .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt),
    .step(step), .svc_chan(svc_chan), .mem_rdata(mem_rdata),
    .io_rdata(io_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .act_chan(act_chan), .bus_addr(bus_addr),
    .wr_data(wr_data), .busy(busy), .peek_chan(peek_chan),
    .peek_addr(peek_addr), .peek_cnt(peek_cnt), .tc_status(tc_status),
    .mask(mask), .hi_chg(hi_chg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_move(input logic [15:0] a, input logic down);
    logic [16:0] t;
    t = down ? ({1'b0, a} + 17'h0FFFF) : ({1'b0, a} + 17'h00001);
    return t[15:0];
  endfunction

  function automatic logic ref_page(input logic [15:0] a, input logic down);
    return down ? (a[7:0] == 8'd255) : (a[7:0] == 8'd0);
  endfunction

  task automatic chk_state(input string req, input int ch);
    chk({req, " peek_addr"}, peek_addr, m_addr[ch]);
    chk({req, " peek_cnt"},  peek_cnt,  m_cnt[ch]);
    chk({req, " tc_status"}, tc_status, m_tc);
    chk({req, " mask"},      mask,      m_mask);
    chk({req, " hi_chg"},    hi_chg,    m_hf);
    chk({req, " wr_data"},   wr_data,   m_temp);
  endtask

  // Entered and left just after a falling edge.
  task automatic do_cfg(input int ch, input logic [3:0] md, input logic [15:0] a, input logic [15:0] c);
    cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_mode = md; cfg_addr = a; cfg_cnt = c;
    peek_chan = 2'(ch);
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode[ch] = md; m_addr[ch] = a; m_ba[ch] = a; m_cnt[ch] = c; m_bc[ch] = c;
    m_mask[ch] = 1'b0; m_tc[ch] = 1'b0; m_hf[ch] = 1'b0;
    chk_state("R2 cfg", ch);
  endtask

  task automatic do_step(input int ch, input logic [7:0] rdm, input logic [7:0] rdi, input bit poke);
    logic [1:0] t;
    logic dn, au, wr;
    logic [15:0] na, nc;
    t = m_mode[ch][1:0]; dn = m_mode[ch][2]; au = m_mode[ch][3];
    peek_chan = 2'(ch); mem_rdata = rdm; io_rdata = rdi;
    step = 1'b1; svc_chan = 2'(ch);
    @(negedge clk);
    step = 1'b0;
    if (m_mask[ch]) begin
      chk("R3 masked step busy", busy, 0);
      chk("R3 masked step strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
      @(negedge clk);
      chk("R3 masked step busy later", busy, 0);
      chk_state("R3 masked unchanged", ch);
      return;
    end
    // read phase
    if (poke) begin step = 1'b1; svc_chan = 2'(ch + 1); end
    chk("R3 busy read phase", busy, 1);
    chk("R4 R5 bus_addr read phase", bus_addr, m_addr[ch]);
    chk("R5 mem_rd", mem_rd, (t == 2'b10));
    chk("R4 io_rd", io_rd, (t == 2'b01));
    chk("R13 no write in read phase", {mem_wr, io_wr}, 0);
    @(negedge clk);
    if (t == 2'b01) m_temp = rdi;
    if (t == 2'b10) m_temp = rdm;
    chk("R3 busy write phase", busy, 1);
    chk("R4 R5 bus_addr write phase", bus_addr, m_addr[ch]);
    chk("R4 mem_wr", mem_wr, (t == 2'b01));
    chk("R5 io_wr", io_wr, (t == 2'b10));
    chk("R6 R7 no read in write phase", {mem_rd, io_rd}, 0);
    chk("R4 R5 R6 wr_data", wr_data, m_temp);
    @(negedge clk);
    step = 1'b0;
    if (t != 2'b11) begin
      na = ref_move(m_addr[ch], dn);
      nc = m_cnt[ch] + 16'hFFFF;
      wr = (nc == 16'hFFFF);
      if (wr) m_tc[ch] = 1'b1;
      if (wr && au) begin
        m_addr[ch] = m_ba[ch]; m_cnt[ch] = m_bc[ch]; m_hf[ch] = 1'b1;
      end else begin
        m_addr[ch] = na; m_cnt[ch] = nc; m_hf[ch] = ref_page(na, dn);
        if (wr) m_mask[ch] = 1'b1;
      end
    end
    chk("R3 idle after two phases", busy, 0);
    chk_state("R8 R9 R10 R11 R12 after step", ch);
  endtask

  initial begin
    void'($urandom(32'h0D1A_5EED));
    rst_n = 1'b0; cfg_we = 0; cfg_chan = 0; cfg_mode = 0; cfg_addr = 0; cfg_cnt = 0;
    step = 0; svc_chan = 0; peek_chan = 0; mem_rdata = 0; io_rdata = 0;
    for (int i = 0; i < 4; i++) begin
      m_mode[i] = 0; m_addr[i] = 0; m_cnt[i] = 0; m_ba[i] = 0; m_bc[i] = 0;
    end
    m_mask = 4'hF; m_tc = 0; m_hf = 0; m_temp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask, 4'hF);
    chk("R1 tc_status", tc_status, 0);
    chk("R1 hi_chg", hi_chg, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk("R1 wr_data", wr_data, 0);
    do_step(0, 8'h11, 8'h22, 0);                 // R3 masked after reset

    // R4 write type, increment across a page (R9)
    do_cfg(0, 4'b0001, 16'h00FF, 16'd2);
    do_step(0, 8'h33, 8'hA5, 0);
    chk("R9 page flag on increment", hi_chg[0], 1);
    do_step(0, 8'h33, 8'h5A, 1);                 // R3 step while busy ignored
    chk("R9 flag cleared", hi_chg[0], 0);
    // R5 read type, decrement, auto-reload at terminal count (R11)
    do_cfg(1, 4'b1110, 16'h0100, 16'd0);
    do_step(1, 8'hC3, 8'h00, 0);
    chk("R11 reload addr", peek_addr, 16'h0100);
    chk("R11 mask stays clear", mask[1], 0);
    chk("R10 status bit 1", tc_status, 4'b0010);
    // R6 verify, address wrap (R8), terminal count without reload (R12)
    do_cfg(2, 4'b0000, 16'hFFFF, 16'd0);
    do_step(2, 8'h77, 8'h88, 0);
    chk("R8 wrap to zero", peek_addr, 16'h0000);
    chk("R12 mask set", mask[2], 1);
    chk("R12 count", peek_cnt, 16'hFFFF);
    do_step(2, 8'h77, 8'h88, 0);                 // R3 now masked
    // R7 illegal type
    do_cfg(3, 4'b0111, 16'h1234, 16'd5);
    do_step(3, 8'h99, 8'h66, 0);
    chk("R7 address unchanged", peek_addr, 16'h1234);
    chk("R7 count unchanged", peek_cnt, 16'd5);
    // R9 decrement crossing
    do_cfg(3, 4'b0101, 16'h0200, 16'd9);
    do_step(3, 8'h01, 8'h02, 0);
    chk("R9 page flag on decrement", hi_chg[3], 1);

    // Constrained random mix
    for (int n = 0; n < 500; n++) begin
      int ch;
      ch = int'($urandom % 4);
      if ($urandom % 4 == 0)
        do_cfg(ch, 4'($urandom), 16'($urandom),
               ($urandom % 2 == 1) ? 16'($urandom % 3) : 16'($urandom % 20));
      else
        do_step(ch, 8'($urandom), 8'($urandom), ($urandom % 8) == 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule